// File: doc/BRIEF.md
# DMA Descriptor Configuration Error Checker

This block watches one DMA channel's transfer descriptor and the transfers made from it, and keeps a status word that holds the most recent error. When software activates the channel, a one-cycle check strobe samples the minor-loop byte count, the source and destination transfer size codes, the current iteration count and the link-enable bits of the current and beginning iteration counts. A clean descriptor lets the channel start. A faulty one records a count/iteration error, and the channel stays stopped.

While the channel runs, a major-loop-complete event with scatter/gather enabled checks that the next-descriptor address lies on a 32-byte boundary. Bus error strobes from source reads and destination writes are also recorded. Only one error type is held at a time, and a newer error replaces an older one. Software clears flags with a write-one-to-clear mask.

The control is a two-state machine. In `ST_IDLE` the channel is stopped, and in `ST_ACTIVE` it is running. The transition `T_START` goes from `ST_IDLE` to `ST_ACTIVE` on a clean check strobe. The transitions `T_DONE` (major loop complete with no scatter/gather), `T_SG_FAULT` (misaligned next descriptor) and `T_BUS_ABORT` (any bus error) go from `ST_ACTIVE` back to `ST_IDLE`. The transition `T_SG_LOAD` (aligned next descriptor) keeps the machine in `ST_ACTIVE`.

Top module: `dma_desc_checker`

## Requirements
- R1: After reset all four error flags, `err_any`, `chan_active` and `start_go` are 0.
- R2: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. On a check, the channel records a count/iteration error if `nbytes` is not a multiple of both sizes. Codes 4 to 7 also record this error.
- R3: A check with `citer` equal to zero records a count/iteration error.
- R4: A check where `citer_link` differs from `biter_link` records a count/iteration error.
- R5: A check strobe is acted on only in ST_IDLE. If it is clean and no bus error arrives in the same cycle, `start_go` pulses for one cycle and `chan_active` rises after that clock edge. A faulty check leaves the channel idle. A check strobe in ST_ACTIVE has no effect.
- R6: The 32-byte alignment check runs only on `major_done` in ST_ACTIVE with `sg_en` high. If address bits [4:0] are not zero, the scatter/gather flag is set and the channel goes idle. An aligned address keeps the channel active. `major_done` with `sg_en` low makes the channel idle and records nothing. `major_done` in ST_IDLE has no effect.
- R7: `src_bus_err` sets the source flag and `dst_bus_err` sets the destination flag in either state. In ST_ACTIVE, either bus error also makes the channel idle.
- R8: At most one flag is set at a time, and a new error replaces the old one. When several errors arrive in the same cycle, the priority is destination, then source, then scatter/gather, then count/iteration.
- R9: `clr_stb` clears the flags selected by `clr_mask` on the next edge. The mask bits are: bit 3 count/iteration, bit 2 scatter/gather, bit 1 source, bit 0 destination. An error recorded in the same cycle takes precedence over the clear.
- R10: `err_any` is high exactly when some error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chk_stb | input | 1 | Activation check strobe |
| nbytes | input | 32 | Minor-loop byte count |
| ssize | input | 3 | Source transfer size code |
| dsize | input | 3 | Destination transfer size code |
| citer | input | 15 | Current iteration count |
| citer_link | input | 1 | Link-enable bit of current count |
| biter_link | input | 1 | Link-enable bit of beginning count |
| sg_en | input | 1 | Scatter/gather enabled in descriptor |
| next_desc | input | 32 | Next-descriptor address |
| major_done | input | 1 | Major loop complete event |
| src_bus_err | input | 1 | Source read bus error strobe |
| dst_bus_err | input | 1 | Destination write bus error strobe |
| clr_stb | input | 1 | Write-one-to-clear command |
| clr_mask | input | 4 | Flags to clear (bit 3 cfg, 2 sg, 1 src, 0 dst) |
| err_cfg | output | 1 | Count/iteration configuration error |
| err_sg | output | 1 | Scatter/gather configuration error |
| err_src | output | 1 | Source bus error |
| err_dst | output | 1 | Destination bus error |
| err_any | output | 1 | Any error flag set |
| chan_active | output | 1 | Channel running (ST_ACTIVE) |
| start_go | output | 1 | One-cycle start grant |

## Verification
The bench targets the cases where a flawed design would go wrong:
- A byte count that is a multiple of one size but not of the other. A design that checks only one size would let the channel start.
- An out-of-range size code. A design that masks the code to two bits would pass it.
- A misaligned next-descriptor address with `sg_en` low, or arriving while idle. A design that checks alignment unconditionally would set a false scatter/gather flag.
- Two bus errors in the same cycle, and a clear that coincides with a new error. A design with the wrong priority would keep the source flag or drop the new error.
- A check strobe while active with a bad descriptor. A design that acts on it would record a spurious count/iteration error.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_ACTIVE = 1'b1} chan_state_e;

    localparam int ERR_N   = 4;
    localparam int IDX_DST = 0;
    localparam int IDX_SRC = 1;
    localparam int IDX_SG  = 2;
    localparam int IDX_CFG = 3;

    function automatic logic size_code_bad(input logic [2:0] code);
        return code > 3'd3;
    endfunction

    // low-bit mask that must be zero in a byte count for a given size code
    function automatic logic [2:0] size_low_mask(input logic [2:0] code);
        logic [2:0] m;
        unique case (code[1:0])
            2'd0: m = 3'b000;
            2'd1: m = 3'b001;
            2'd2: m = 3'b011;
            default: m = 3'b111;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/dcc_cfg_check.sv
module dcc_cfg_check
    import dcc_pkg::*;
#(
    parameter int NB_W  = 32,
    parameter int CIT_W = 15
) (
    input  logic [NB_W-1:0]  nbytes,
    input  logic [2:0]       ssize,
    input  logic [2:0]       dsize,
    input  logic [CIT_W-1:0] citer,
    input  logic             citer_link,
    input  logic             biter_link,
    output logic             bad
);
    logic [2:0] need_zero;
    logic       code_bad, mult_bad, count_bad, link_bad;

    always_comb begin
        need_zero = size_low_mask(ssize) | size_low_mask(dsize);
        code_bad  = size_code_bad(ssize) || size_code_bad(dsize);
        mult_bad  = (nbytes[2:0] & need_zero) != 3'b000;
        count_bad = citer == '0;
        link_bad  = citer_link != biter_link;
        bad       = code_bad || mult_bad || count_bad || link_bad;
    end
endmodule

// File: rtl/dcc_sg_check.sv
module dcc_sg_check #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_LOG2 = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              misaligned
);
    localparam logic [ALIGN_LOG2-1:0] ZERO_LOW = '0;

    assign misaligned = addr[ALIGN_LOG2-1:0] != ZERO_LOW;
endmodule

// File: rtl/dcc_err_record.sv
module dcc_err_record #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         clr_stb,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);
    logic [N-1:0] pick;
    logic         found;

    // lowest index wins (destination bus error first)
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (ev[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flags <= '0;
        else if (|ev)     flags <= pick;
        else if (clr_stb) flags <= flags & ~clr_mask;
    end

    p_one_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));

    p_clear_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && ev == '0) |=> ((flags & $past(clr_mask)) == '0));

    p_new_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ($countones(flags) == 1));
endmodule

// File: rtl/dma_desc_checker.sv
module dma_desc_checker
    import dcc_pkg::*;
#(
    parameter int NB_W       = 32,
    parameter int CIT_W      = 15,
    parameter int ADDR_W     = 32,
    parameter int ALIGN_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_stb,
    input  logic [NB_W-1:0]   nbytes,
    input  logic [2:0]        ssize,
    input  logic [2:0]        dsize,
    input  logic [CIT_W-1:0]  citer,
    input  logic              citer_link,
    input  logic              biter_link,
    input  logic              sg_en,
    input  logic [ADDR_W-1:0] next_desc,
    input  logic              major_done,
    input  logic              src_bus_err,
    input  logic              dst_bus_err,
    input  logic              clr_stb,
    input  logic [3:0]        clr_mask,
    output logic              err_cfg,
    output logic              err_sg,
    output logic              err_src,
    output logic              err_dst,
    output logic              err_any,
    output logic              chan_active,
    output logic              start_go
);
    chan_state_e      state, state_n;
    logic             cfg_bad, sg_misaligned, bus_hit;
    logic             go_n, sg_ev, cfg_ev;
    logic [ERR_N-1:0] ev, flags;

    dcc_cfg_check #(.NB_W(NB_W), .CIT_W(CIT_W)) u_cfg (
        .nbytes(nbytes), .ssize(ssize), .dsize(dsize), .citer(citer),
        .citer_link(citer_link), .biter_link(biter_link), .bad(cfg_bad)
    );

    dcc_sg_check #(.ADDR_W(ADDR_W), .ALIGN_LOG2(ALIGN_LOG2)) u_sg (
        .addr(next_desc), .misaligned(sg_misaligned)
    );

    assign bus_hit = src_bus_err || dst_bus_err;

    // next state and event decode
    always_comb begin
        state_n = state;
        go_n    = 1'b0;
        sg_ev   = 1'b0;
        cfg_ev  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (chk_stb) begin
                    if (cfg_bad) begin
                        cfg_ev = 1'b1;
                    end else if (!bus_hit) begin
                        go_n    = 1'b1;          // T_START
                        state_n = ST_ACTIVE;
                    end
                end
            end
            ST_ACTIVE: begin
                if (bus_hit) begin
                    state_n = ST_IDLE;           // T_BUS_ABORT
                end else if (major_done) begin
                    if (!sg_en) begin
                        state_n = ST_IDLE;       // T_DONE
                    end else if (sg_misaligned) begin
                        sg_ev   = 1'b1;          // T_SG_FAULT
                        state_n = ST_IDLE;
                    end
                    // aligned: T_SG_LOAD, stay active
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            start_go <= 1'b0;
        end else begin
            state    <= state_n;
            start_go <= go_n;
        end
    end

    always_comb begin
        ev          = '0;
        ev[IDX_DST] = dst_bus_err;
        ev[IDX_SRC] = src_bus_err;
        ev[IDX_SG]  = sg_ev;
        ev[IDX_CFG] = cfg_ev;
    end

    dcc_err_record #(.N(ERR_N)) u_rec (
        .clk(clk), .rst_n(rst_n), .ev(ev),
        .clr_stb(clr_stb), .clr_mask(clr_mask), .flags(flags)
    );

    assign err_dst     = flags[IDX_DST];
    assign err_src     = flags[IDX_SRC];
    assign err_sg      = flags[IDX_SG];
    assign err_cfg     = flags[IDX_CFG];
    assign err_any     = |flags;
    assign chan_active = state == ST_ACTIVE;

    p_start_from_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |-> ($past(chk_stb) && $past(state) == ST_IDLE && chan_active));

    p_no_start_on_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_cfg) |-> !start_go);

    p_sg_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sg) |-> ($past(state) == ST_ACTIVE && $past(major_done) && $past(sg_en)));

    p_bus_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_active && bus_hit) |=> !chan_active);
endmodule

// File: tb/tb_dma_desc_checker.sv
`timescale 1ns/1ps
module tb_dma_desc_checker;
    typedef struct {
        logic [3:0] flags;
        logic       go;
        logic       act;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_stb = 0, citer_link = 0, biter_link = 0, sg_en = 0;
    logic        major_done = 0, src_bus_err = 0, dst_bus_err = 0, clr_stb = 0;
    logic [31:0] nbytes = 0, next_desc = 0;
    logic [2:0]  ssize = 0, dsize = 0;
    logic [14:0] citer = 0;
    logic [3:0]  clr_mask = 0;
    logic        err_cfg, err_sg, err_src, err_dst, err_any, chan_active, start_go;

    int   checks = 0, errors = 0;
    exp_t sb[$];
    logic [3:0] m_flags = 0;   // bit3 cfg, 2 sg, 1 src, 0 dst
    logic       m_act = 0;

    always #2 clk = ~clk;

    dma_desc_checker dut (
        .clk(clk), .rst_n(rst_n), .chk_stb(chk_stb), .nbytes(nbytes),
        .ssize(ssize), .dsize(dsize), .citer(citer), .citer_link(citer_link),
        .biter_link(biter_link), .sg_en(sg_en), .next_desc(next_desc),
        .major_done(major_done), .src_bus_err(src_bus_err), .dst_bus_err(dst_bus_err),
        .clr_stb(clr_stb), .clr_mask(clr_mask), .err_cfg(err_cfg), .err_sg(err_sg),
        .err_src(err_src), .err_dst(err_dst), .err_any(err_any),
        .chan_active(chan_active), .start_go(start_go)
    );

    function automatic logic [2:0] lowmask(input logic [2:0] c);
        return (c == 3'd0) ? 3'b000 : (c == 3'd1) ? 3'b001 : (c == 3'd2) ? 3'b011 : 3'b111;
    endfunction

    task automatic check(input string req, input string what, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    // driver: model one edge from the current inputs, push expected result
    task automatic tick(input string req);
        exp_t e;
        logic cbad, sbad, go, bus;
        logic [3:0] ev, pick;
        cbad = (ssize > 3'd3) || (dsize > 3'd3) ||
               ((nbytes[2:0] & (lowmask(ssize) | lowmask(dsize))) != 3'b000) ||
               (citer == 15'd0) || (citer_link != biter_link);
        bus  = src_bus_err || dst_bus_err;
        sbad = m_act && !bus && major_done && sg_en && (next_desc[4:0] != 5'd0);
        ev   = {chk_stb && !m_act && cbad, sbad, src_bus_err, dst_bus_err};
        pick = ev[0] ? 4'b0001 : ev[1] ? 4'b0010 : ev[2] ? 4'b0100 : ev[3] ? 4'b1000 : 4'b0000;
        go   = chk_stb && !m_act && !cbad && !bus;
        if (ev != 4'b0)   m_flags = pick;
        else if (clr_stb) m_flags = m_flags & ~clr_mask;
        if (!m_act) m_act = go;
        else if (bus) m_act = 1'b0;
        else if (major_done && (!sg_en || next_desc[4:0] != 5'd0)) m_act = 1'b0;
        @(posedge clk);
        #1;
        e.flags = m_flags; e.go = go; e.act = m_act; e.req = req;
        sb.push_back(e);
        chk_stb = 0; major_done = 0; src_bus_err = 0; dst_bus_err = 0; clr_stb = 0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, "flags", {err_cfg, err_sg, err_src, err_dst}, e.flags);
            check(e.req, "start_go", {3'b0, start_go}, {3'b0, e.go});
            check(e.req, "chan_active", {3'b0, chan_active}, {3'b0, e.act});
            check("R10", "err_any", {3'b0, err_any}, {3'b0, |e.flags});
        end
    end

    task automatic good_desc();
        nbytes = 32'd16; ssize = 3'd2; dsize = 3'd3; citer = 15'd5;
        citer_link = 1; biter_link = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset flags", {err_cfg, err_sg, err_src, err_dst}, 4'b0);
        check("R1", "reset active/go/any", {1'b0, chan_active, start_go, err_any}, 4'b0);
        rst_n = 1;
        @(posedge clk); #1;
        tick("R1");                                            // idle cycle
        good_desc(); chk_stb = 1; tick("R5 clean start");
        nbytes = 32'd3; chk_stb = 1; tick("R5 check while active ignored");
        sg_en = 1; next_desc = 32'h1000_0040; major_done = 1; tick("R6 aligned sg stays active");
        next_desc = 32'h1000_0044; major_done = 1; tick("R6 misaligned sg");
        good_desc(); nbytes = 32'd6; ssize = 3'd0; dsize = 3'd2; chk_stb = 1;
        tick("R2 multiple of one size only");
        good_desc(); ssize = 3'd5; chk_stb = 1; tick("R2 bad size code");
        clr_stb = 1; clr_mask = 4'b1000; tick("R9 clear cfg");
        good_desc(); citer = 15'd0; chk_stb = 1; tick("R3 zero citer");
        clr_stb = 1; clr_mask = 4'b0111; tick("R9 clear other bits keeps cfg");
        good_desc(); biter_link = 0; chk_stb = 1; tick("R4 link mismatch");
        src_bus_err = 1; tick("R7 src bus error in idle");
        major_done = 1; sg_en = 1; next_desc = 32'h3; tick("R6 major_done idle ignored");
        good_desc(); chk_stb = 1; tick("R5 start again");
        src_bus_err = 1; dst_bus_err = 1; tick("R8 dst over src");
        good_desc(); chk_stb = 1; tick("R5 start third");
        sg_en = 0; next_desc = 32'h7; major_done = 1; tick("R6 done without sg");
        clr_stb = 1; clr_mask = 4'b1111; src_bus_err = 1; tick("R9 error beats clear");
        clr_stb = 1; clr_mask = 4'b1111; tick("R9 clear all");
        good_desc(); ssize = 3'd1; dsize = 3'd1; nbytes = 32'd2; chk_stb = 1;
        tick("R2 2-byte sizes clean");
        @(negedge clk); @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule